// File: doc/BRIEF.md
# Stereo Audio Presence Detector

This block decides, separately for a left and a right audio channel, whether a signal is present. An external level comparator supplies one bit per channel that is high whenever the instantaneous input level exceeds a threshold. The block passes each comparator bit through a two-flop synchronizer. It samples the result only on cycles where the periodic sample strobe is high, nominally at 100 kHz.

A channel becomes present once enough above-threshold samples arrive back to back. The number of samples needed is programmable. A channel stays present as long as qualifying runs keep recurring. It drops back to absent after a programmable recovery window of strobes passes with no qualifying sample. A 3-bit source select turns detection off (code 0) or names one of seven input pairs. The pair routing itself happens outside this block, so the select only enables or disables detection here.

Configuration is captured on a one-cycle write pulse. That write also restarts every counter and clears both status bits. Interrupt masking happens downstream and has no path into this block. There is no data stream, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `audio_presence_det`

## Requirements
- R1: After reset both presence outputs are 0. The captured configuration is: source off, run code 00, recovery code 01.
- R2: While the captured source select is 000, both presence outputs stay 0 whatever the comparator bits do. Codes 001 to 111 enable detection.
- R3: A channel's presence output rises on the strobe that completes N consecutive above-threshold samples, with N = 1, 2, 4, 8 for run codes 00, 01, 10, 11.
- R4: A strobe that samples a below-threshold value resets that channel's consecutive-run count to zero.
- R5: A present channel clears on the L-th consecutive strobe without a qualifying sample, with L = REC_BASE × 1, 2, 4, 8 for recovery codes 00, 01, 10, 11. With the default REC_BASE of 4000 these windows are 40, 80, 160 and 320 ms at 100 kHz.
- R6: Every strobe whose sample extends a run to at least N restarts the recovery window.
- R7: Left and right run independently, each with its own counters and output.
- R8: A cycle with cfg_wr high loads src_sel, run_code and rec_code. On the next cycle both outputs are 0, and all run and recovery counts restart from zero.
- R9: Comparator values reach the sampler two clock edges after they are applied. Cycles without the strobe change no presence output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe, one cycle wide |
| cmp_l | input | 1 | Left comparator bit, asynchronous |
| cmp_r | input | 1 | Right comparator bit, asynchronous |
| src_sel | input | 3 | Source select; 000 disables detection |
| run_code | input | 2 | Consecutive-sample count code |
| rec_code | input | 2 | Recovery window code |
| cfg_wr | input | 1 | Configuration write pulse |
| pres_l | output | 1 | Left presence status |
| pres_r | output | 1 | Right presence status |

## Verification
The hardest situation to reach is a present channel whose recovery window is about to expire, while a run one sample short of N arrives. The bench sets up this case directly. It uses a shortened REC_BASE, so that full windows fit in a short run. It qualifies once, then feeds exactly N−1 high samples and a low sample just before the window closes, and checks that the output still falls on schedule. The bench also runs constrained-random segments with a varying high-sample density and random strobe gaps. In these segments, writes land at random points inside open runs and windows.

// File: rtl/apd_pkg.sv
package apd_pkg;
  typedef struct packed {
    logic [2:0] src;
    logic [1:0] run;
    logic [1:0] rec;
  } apd_cfg_t;

  localparam logic [2:0] SRC_OFF     = 3'd0;
  localparam logic [1:0] RUN_DEFAULT = 2'd0;
  localparam logic [1:0] REC_DEFAULT = 2'd1;
  localparam int         RUN_W       = 4;

  function automatic logic [RUN_W-1:0] run_need(input logic [1:0] code);
    return RUN_W'(1) << code;
  endfunction
endpackage

// File: rtl/apd_sync.sv
module apd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/apd_cfg.sv
module apd_cfg
  import apd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] src_sel,
  input  logic [1:0] run_code,
  input  logic [1:0] rec_code,
  output apd_cfg_t   cfg,
  output logic       en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '{src: SRC_OFF, run: RUN_DEFAULT, rec: REC_DEFAULT};
    end else if (wr) begin
      cfg <= '{src: src_sel, run: run_code, rec: rec_code};
    end
  end

  assign en = (cfg.src != SRC_OFF);

  // R8
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cfg.src == $past(src_sel)) && (cfg.rec == $past(rec_code)));
endmodule

// File: rtl/apd_chan.sv
module apd_chan
  import apd_pkg::*;
#(
  parameter int REC_BASE = 4000,
  localparam int REC_W = $clog2(REC_BASE * 8 + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb,
  input  logic       smp,
  input  logic       en,
  input  logic       clr,
  input  logic [1:0] run_code,
  input  logic [1:0] rec_code,
  output logic       pres
);
  logic [RUN_W-1:0] run_cnt;
  logic [REC_W-1:0] rec_cnt;
  logic [RUN_W-1:0] need;
  logic [REC_W-1:0] lim;
  logic             qual;
  logic             win_end;

  assign need    = run_need(run_code);
  assign lim     = REC_W'(REC_BASE) << rec_code;
  assign qual    = stb && smp && (run_cnt >= need - RUN_W'(1));
  assign win_end = (rec_cnt == lim - REC_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      rec_cnt <= '0;
      pres    <= 1'b0;
    end else if (clr || !en) begin
      run_cnt <= '0;
      rec_cnt <= '0;
      pres    <= 1'b0;
    end else if (stb) begin
      if (!smp)              run_cnt <= '0;
      else if (run_cnt < need) run_cnt <= run_cnt + RUN_W'(1);
      if (qual) begin
        pres    <= 1'b1;
        rec_cnt <= '0;
      end else if (pres) begin
        if (win_end) begin
          pres    <= 1'b0;
          rec_cnt <= '0;
        end else begin
          rec_cnt <= rec_cnt + REC_W'(1);
        end
      end else begin
        rec_cnt <= '0;
      end
    end
  end

  // R2
  off_holds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pres);
  // R8
  clr_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!pres && run_cnt == '0 && rec_cnt == '0));
  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && !clr && en) |=> $stable(pres));
  // R3
  rise_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pres) |-> $past(stb && smp));
  // R4
  low_resets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !smp) |=> run_cnt == '0);
  // R6
  qual_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !clr && en) |=> (pres && rec_cnt == '0));
endmodule

// File: rtl/audio_presence_det.sv
module audio_presence_det
  import apd_pkg::*;
#(
  parameter int REC_BASE    = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_stb,
  input  logic       cmp_l,
  input  logic       cmp_r,
  input  logic [2:0] src_sel,
  input  logic [1:0] run_code,
  input  logic [1:0] rec_code,
  input  logic       cfg_wr,
  output logic       pres_l,
  output logic       pres_r
);
  localparam int NCH = 2;

  apd_cfg_t         cfg;
  logic             en;
  logic [NCH-1:0]   cmp_raw;
  logic [NCH-1:0]   cmp_syn;
  logic [NCH-1:0]   pres;

  assign cmp_raw = {cmp_r, cmp_l};

  apd_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .src_sel  (src_sel),
    .run_code (run_code),
    .rec_code (rec_code),
    .cfg      (cfg),
    .en       (en)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    apd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_raw[c]),
      .q     (cmp_syn[c])
    );
    apd_chan #(.REC_BASE(REC_BASE)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (smp_stb),
      .smp      (cmp_syn[c]),
      .en       (en),
      .clr      (cfg_wr),
      .run_code (cfg.run),
      .rec_code (cfg.rec),
      .pres     (pres[c])
    );
  end

  assign pres_l = pres[0];
  assign pres_r = pres[1];

  // R8
  write_clears_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!pres_l && !pres_r));
endmodule

// File: tb/sim_audio_presence_det.sv
module sim_audio_presence_det;
  localparam int CLK_PERIOD = 10;
  localparam int RB = 20;

  logic clk = 1'b0, rst_n = 1'b0, smp_stb = 1'b0, cmp_l = 1'b0, cmp_r = 1'b0, cfg_wr = 1'b0;
  logic [2:0] src_sel = 3'd0;
  logic [1:0] run_code = 2'd0, rec_code = 2'd0;
  logic pres_l, pres_r;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  audio_presence_det #(.REC_BASE(RB)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .cmp_l(cmp_l), .cmp_r(cmp_r),
    .src_sel(src_sel), .run_code(run_code), .rec_code(rec_code), .cfg_wr(cfg_wr),
    .pres_l(pres_l), .pres_r(pres_r));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model built from the requirement text
  logic [2:0] m_src; logic [1:0] m_run, m_rec;
  logic m_s1[2], m_s2[2], m_p[2];
  int   m_cnt[2], m_rc[2];

  function automatic int need_of(logic [1:0] c); return 1 << c; endfunction
  function automatic int win_of(logic [1:0] c);  return RB << c; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 3'd0; m_run = 2'd0; m_rec = 2'd1;
      for (int c = 0; c < 2; c++) begin
        m_s1[c] = 0; m_s2[c] = 0; m_p[c] = 0; m_cnt[c] = 0; m_rc[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (cfg_wr || m_src == 3'd0) begin
          m_p[c] = 0; m_cnt[c] = 0; m_rc[c] = 0;
        end else if (smp_stb) begin
          m_cnt[c] = m_s2[c] ? m_cnt[c] + 1 : 0;
          if (m_cnt[c] >= need_of(m_run)) begin
            m_p[c] = 1; m_rc[c] = 0;
          end else if (m_p[c]) begin
            m_rc[c]++;
            if (m_rc[c] == win_of(m_rec)) begin m_p[c] = 0; m_rc[c] = 0; end
          end
        end
      end
      if (cfg_wr) begin m_src = src_sel; m_run = run_code; m_rec = rec_code; end
      m_s2[0] = m_s1[0]; m_s2[1] = m_s1[1];
      m_s1[0] = cmp_l;   m_s1[1] = cmp_r;
    end
  end

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cfg(logic [2:0] s, logic [1:0] r, logic [1:0] w);
    @(negedge clk); src_sel = s; run_code = r; rec_code = w; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
    check("R8 write clears", {pres_r, pres_l}, 2'b00);
  endtask

  task automatic set_cmp(logic l, logic r);
    @(negedge clk); cmp_l = l; cmp_r = r;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); smp_stb = 1;
      @(negedge clk); smp_stb = 0;
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cycles++;
      if (cycles > 190000) begin
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD*3); rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", {pres_r, pres_l}, 2'b00);
    // R2: off mode ignores comparators
    set_cmp(1, 1); strobe(10);
    check("R2 off holds low", {pres_r, pres_l}, 2'b00);
    // R3: code 11 needs 8
    cfg(3'd3, 2'd3, 2'd0);
    set_cmp(1, 1); strobe(7);
    check("R3 seven of eight", {pres_r, pres_l}, 2'b00);
    strobe(1);
    check("R3 eighth asserts", {pres_r, pres_l}, 2'b11);
    // R9: no strobe, no change even with comparator low
    set_cmp(0, 0);
    repeat (30) @(negedge clk);
    check("R9 idle without strobe", {pres_r, pres_l}, 2'b11);
    // R5: window 20 strobes at code 00
    strobe(19);
    check("R5 before window end", {pres_r, pres_l}, 2'b11);
    strobe(1);
    check("R5 window end clears", {pres_r, pres_l}, 2'b00);
    // R4: broken run of code 10 (need 4)
    cfg(3'd7, 2'd2, 2'd0);
    set_cmp(1, 0); strobe(3);
    set_cmp(0, 0); strobe(1);
    set_cmp(1, 0); strobe(3);
    check("R4 low resets run", {pres_r, pres_l}, 2'b00);
    strobe(1);
    check("R7 left only", {pres_r, pres_l}, 2'b01);
    // R6: short run near window end does not extend; full run does
    set_cmp(0, 0); strobe(15);
    set_cmp(1, 0); strobe(3);
    set_cmp(0, 0); strobe(1);
    check("R6 short run no restart", {pres_r, pres_l}, 2'b01);
    strobe(1);
    check("R6 window expires", {pres_r, pres_l}, 2'b00);
    cfg(3'd1, 2'd0, 2'd1);
    set_cmp(0, 1); strobe(1);
    check("R3 code 00 one sample", {pres_r, pres_l}, 2'b10);
    set_cmp(0, 0); strobe(39);
    set_cmp(0, 1); strobe(1);
    set_cmp(0, 0); strobe(39);
    check("R6 qualifying restart", {pres_r, pres_l}, 2'b10);
    strobe(1);
    check("R5 code 01 window", {pres_r, pres_l}, 2'b00);
    // R8: write mid-presence clears
    set_cmp(1, 1); strobe(1);
    cfg(3'd2, 2'd1, 2'd3);
    strobe(1);
    check("R8 run restarted", {pres_r, pres_l}, 2'b00);
    // random phase against reference model
    for (int seg = 0; seg < 24; seg++) begin
      int dens_l, dens_r, sprob;
      dens_l = $urandom_range(0, 8); dens_r = $urandom_range(0, 8);
      sprob = $urandom_range(1, 4);
      @(negedge clk);
      if (seg % 3 == 0) begin
        src_sel = 3'($urandom_range(0, 7)); run_code = 2'($urandom_range(0, 3));
        rec_code = 2'($urandom_range(0, 3)); cfg_wr = 1;
      end
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        check("R3 R4 R5 R6 R7 R9 model", {pres_r, pres_l}, {m_p[1], m_p[0]});
        cfg_wr  = ($urandom_range(0, 999) == 0);
        if (cfg_wr) begin
          src_sel = 3'($urandom_range(1, 7)); run_code = 2'($urandom_range(0, 3));
          rec_code = 2'($urandom_range(0, 1));
        end
        smp_stb = ($urandom_range(1, sprob) == 1);
        cmp_l   = ($urandom_range(0, 7) < dens_l);
        cmp_r   = ($urandom_range(0, 7) < dens_r);
      end
    end
    @(negedge clk); cfg_wr = 0; smp_stb = 0;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule